// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block turns a single asynchronous serial line into parallel bytes. The line rests high. Each character arrives as a frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. A correct frame produces a byte on the data output together with a valid strobe that lasts one cycle. A malformed frame produces an error strobe and no byte.

The rate is set at run time by a divider input. One bit lasts the divider value plus one system clocks. The line is first brought into the clock domain through a two-stage synchronizer. A falling edge on an idle line is checked again half a bit later. If the line is still low, the start bit is confirmed, and every later bit is sampled once per bit period near its centre.

A busy flag is high while a frame is being taken in. A controller waits for the flag to drop before it writes a new divider value. The divider is captured when a start bit is detected, so a value written during a frame takes effect at the next frame.

Top module: `uart_byte_rx`

## Requirements
- R1: A frame made of a low start bit, eight data bits least significant bit first, and a high stop bit produces one `rx_valid` pulse of exactly one cycle, with `rx_data` holding the eight data bits (bit 0 is the first data bit on the line).
- R2: A bit lasts `divider`+1 clocks, for divider values from 3 to 31. When the stop bit is sampled, a pulse on `rx_valid` or `rx_error` appears 1 + floor(`divider`/2) + 9×(`divider`+1) cycles after `rx_busy` rises.
- R3: The divider is captured at start-bit detection. Writing a different value during a frame does not disturb that frame. A value written between frames is used for the next frame, with no stray strobe.
- R4: If the stop bit is sampled low, `rx_error` pulses for one cycle and `rx_valid` does not pulse for that frame.
- R5: If the line returns high before the middle of the start bit, `rx_error` pulses for one cycle, 1 + floor(`divider`/2) cycles after `rx_busy` rises, and no byte is delivered.
- R6: After a frame with a low stop bit, a line that stays low produces no further strobe. A new frame is accepted only after the line has returned high.
- R7: `rx_busy` is high from start detection until the cycle in which the frame's strobe is raised, and low while idle. Each time it drops without a reset, `rx_valid` or `rx_error` is high.
- R8: `rx_valid` and `rx_error` are never high in the same cycle.
- R9: `rx_data` changes only together with an `rx_valid` pulse. It keeps its value across error strobes.
- R10: While `rst_n` is low, `rx_busy`, `rx_valid` and `rx_error` are low and `rx_data` is zero. A reset during a frame abandons that frame without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| divider | input | 5 | Bit period minus one, in clocks |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| rx_data | output | 8 | Last byte received correctly |
| rx_valid | output | 1 | One-cycle strobe: new byte on `rx_data` |
| rx_error | output | 1 | One-cycle strobe: malformed frame or false start |
| rx_busy | output | 1 | High while a frame is being received |

## Verification
The bound checker watches several properties on every cycle:
- the two strobes never overlap, and each lasts one cycle;
- the data output holds between valid pulses;
- every drop of the busy flag carries a strobe;
- the outputs are quiet during reset.

Other behaviour shows up only in the bench's scenarios:
- the bit order on the line;
- the exact strobe latency for each divider value;
- divider capture while a frame is in flight;
- false-start and break handling, and abandoning a frame on reset.

The bench's scoreboard compares each of these against items queued by the driver.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Receiver sequencing states
  typedef enum logic [2:0] {
    RX_ARM   = 3'd0,  // wait for the line to be high before arming
    RX_IDLE  = 3'd1,  // armed, waiting for a falling edge
    RX_START = 3'd2,  // confirming the start bit at mid-bit
    RX_DATA  = 3'd3,  // sampling data bits
    RX_STOP  = 3'd4   // sampling the stop bit
  } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         tick
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic [DIV_W-1:0]  divider,
  input  logic              tick,
  output logic              load,
  output logic [DIV_W-1:0]  load_val,
  output logic              run,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              error,
  output logic              busy
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rx_state_e          state_q, state_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               valid_q, valid_d;
  logic               error_q, error_d;
  logic               div_en, sh_en, data_en;

  always_comb begin
    state_d  = state_q;
    div_d    = div_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    data_d   = data_q;
    valid_d  = 1'b0;
    error_d  = 1'b0;
    div_en   = 1'b0;
    sh_en    = 1'b0;
    data_en  = 1'b0;
    load     = 1'b0;
    load_val = div_q;
    unique case (state_q)
      RX_ARM: begin
        if (line) state_d = RX_IDLE;
      end
      RX_IDLE: begin
        if (!line) begin
          state_d  = RX_START;
          div_d    = divider;
          div_en   = 1'b1;
          load     = 1'b1;
          load_val = divider >> 1;
        end
      end
      RX_START: begin
        if (tick) begin
          if (!line) begin
            state_d = RX_DATA;
            bit_d   = '0;
            load    = 1'b1;
          end else begin
            state_d = RX_IDLE;
            error_d = 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          sh_d  = {line, sh_q[DATA_W-1:1]};
          sh_en = 1'b1;
          load  = 1'b1;
          if (bit_q == LAST_BIT) state_d = RX_STOP;
          else                   bit_d   = bit_q + BIT_W'(1);
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (line) begin
            state_d = RX_IDLE;
            valid_d = 1'b1;
            data_d  = sh_q;
            data_en = 1'b1;
          end else begin
            state_d = RX_ARM;
            error_d = 1'b1;
          end
        end
      end
      default: state_d = RX_ARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_ARM;
      bit_q   <= '0;
      valid_q <= 1'b0;
      error_q <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      valid_q <= valid_d;
      error_q <= error_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign busy  = (state_q == RX_START) || (state_q == RX_DATA) || (state_q == RX_STOP);
  assign run   = busy;
  assign data  = data_q;
  assign valid = valid_q;
  assign error = error_q;

endmodule

// File: rtl/uart_byte_rx.sv
module uart_byte_rx #(
  parameter int DIV_W       = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divider,
  input  logic              rx_line,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_error,
  output logic              rx_busy
);

  logic             line_s;
  logic             tmr_load;
  logic [DIV_W-1:0] tmr_val;
  logic             tmr_run;
  logic             tmr_tick;

  uart_rx_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (rx_line),
    .d_out (line_s)
  );

  uart_rx_timer #(
    .W (DIV_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .tick     (tmr_tick)
  );

  uart_rx_ctrl #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .line     (line_s),
    .divider  (divider),
    .tick     (tmr_tick),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .data     (rx_data),
    .valid    (rx_valid),
    .error    (rx_error),
    .busy     (rx_busy)
  );

endmodule

// File: rtl/uart_byte_rx_chk.sv
module uart_byte_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_error,
  input logic              rx_busy
);

  assert_strobes_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_error));

  assert_valid_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_error_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |=> !rx_error);

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  assert_busy_drop_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_busy) |-> (rx_valid || rx_error));

  assert_strobe_ends_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || rx_error) |-> (!rx_busy && $past(rx_busy)));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert (!rx_busy && !rx_valid && !rx_error && (rx_data == '0));
    end
  end

endmodule

bind uart_byte_rx uart_byte_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_data  (rx_data),
  .rx_valid (rx_valid),
  .rx_error (rx_error),
  .rx_busy  (rx_busy)
);

// File: tb/uart_byte_rx_test.sv
module uart_byte_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  typedef struct packed {
    logic        err;
    logic [7:0]  data;
    logic [31:0] elapsed;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [4:0] divider;
  logic       rx_line;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_error;
  logic       rx_busy;

  int   checks;
  int   errors;
  int   cyc;
  int   busy_start;
  bit   busy_prev;
  bit   done;
  logic [7:0] last_good;
  exp_t exp_q[$];

  uart_byte_rx uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .divider  (divider),
    .rx_line  (rx_line),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_error (rx_error),
    .rx_busy  (rx_busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_busy && !busy_prev) busy_start = cyc;
      if (rx_valid || rx_error) begin
        check(!(rx_valid && rx_error), "R8 strobes exclusive", {rx_valid, rx_error}, 2);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected strobe", {rx_valid, rx_error}, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rx_error == e.err, "R4 strobe kind (error)", rx_error, e.err);
          check((cyc - busy_start) == int'(e.elapsed), "R2 strobe latency", cyc - busy_start, e.elapsed);
          if (rx_valid && !e.err) begin
            check(rx_data == e.data, "R1 received byte", rx_data, e.data);
            last_good = rx_data;
          end else if (rx_error) begin
            check(rx_data == last_good, "R9 data held on error", rx_data, last_good);
          end
        end
      end
      busy_prev = rx_busy;
    end else begin
      busy_prev = 1'b0;
    end
  end

  function automatic int frame_time(input int d);
    return 1 + (d >> 1) + 9 * (d + 1);
  endfunction

  task automatic send_frame(input logic [4:0] d, input logic [7:0] val, input bit stop_ok,
                            input bit mid_chg, input logic [4:0] mid_d);
    exp_t e;
    int n;
    @(negedge clk);
    check(!rx_busy, "R7 busy low while idle", rx_busy, 0);
    divider = d;
    repeat (3) @(negedge clk);
    n = int'(d) + 1;
    e.err = !stop_ok;
    e.data = val;
    e.elapsed = 32'(frame_time(int'(d)));
    exp_q.push_back(e);
    rx_line = 1'b0;
    repeat (n) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = val[i];
      if (mid_chg && i == 4) divider = mid_d;
      repeat (n) @(negedge clk);
    end
    rx_line = stop_ok;
    repeat (n) @(negedge clk);
    if (stop_ok) rx_line = 1'b1;
  endtask

  task automatic send_glitch(input logic [4:0] d, input int len);
    exp_t e;
    @(negedge clk);
    divider = d;
    repeat (3) @(negedge clk);
    e.err = 1'b1;
    e.data = 8'h00;
    e.elapsed = 32'(1 + (int'(d) >> 1));
    exp_q.push_back(e);
    rx_line = 1'b0;
    repeat (len) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * (int'(d) + 1)) @(negedge clk);
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0; busy_start = 0; busy_prev = 1'b0;
    done = 1'b0; last_good = 8'h00;
    rst_n = 1'b0; divider = 5'd15; rx_line = 1'b1;
    repeat (3) @(negedge clk);
    check(!rx_busy && !rx_valid && !rx_error, "R10 quiet in reset", {rx_busy, rx_valid, rx_error}, 0);
    check(rx_data == 8'h00, "R10 data zero in reset", rx_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2: basic patterns at several rates
    send_frame(5'd15, 8'hA5, 1'b1, 1'b0, 5'd0);
    send_frame(5'd15, 8'h3C, 1'b1, 1'b0, 5'd0);
    send_frame(5'd3,  8'h00, 1'b1, 1'b0, 5'd0);
    send_frame(5'd3,  8'hFF, 1'b1, 1'b0, 5'd0);
    send_frame(5'd31, 8'h81, 1'b1, 1'b0, 5'd0);
    // R3: divider written mid-frame is ignored; the next frame uses a new rate
    send_frame(5'd7,  8'h5A, 1'b1, 1'b1, 5'd2);
    send_frame(5'd4,  8'h96, 1'b1, 1'b0, 5'd0);
    // R4 / R6: low stop bit, then the line stays low (break) before recovering
    send_frame(5'd15, 8'h77, 1'b0, 1'b0, 5'd0);
    repeat (48) @(negedge clk);
    check(exp_q.size() == 0, "R6 no strobe during break", exp_q.size(), 0);
    rx_line = 1'b1;
    repeat (8) @(negedge clk);
    send_frame(5'd15, 8'h12, 1'b1, 1'b0, 5'd0);
    // R5: start too short
    send_glitch(5'd15, 3);
    send_frame(5'd15, 8'h34, 1'b1, 1'b0, 5'd0);
    repeat (20) @(negedge clk);
    check(rx_data == 8'h34, "R9 data held after valid", rx_data, 8'h34);

    // R10: reset during a frame
    divider = 5'd15;
    repeat (3) @(negedge clk);
    rx_line = 1'b0;
    repeat (40) @(negedge clk);
    check(rx_busy, "R7 busy during frame", rx_busy, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(!rx_busy && !rx_valid && !rx_error, "R10 reset mid-frame quiet", {rx_busy, rx_valid, rx_error}, 0);
    check(rx_data == 8'h00, "R10 data cleared", rx_data, 0);
    rx_line = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    last_good = 8'h00;
    repeat (200) @(negedge clk);
    check(!rx_busy, "R10 idle after reset", rx_busy, 0);
    send_frame(5'd9, 8'hE7, 1'b1, 1'b0, 5'd0);
    repeat (30) @(negedge clk);

    check(exp_q.size() == 0, "R1 all expected strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule